// File: doc/BRIEF.md
# Port Input Capture and Pulse Accumulator

This block holds the externally driven input ports of a small microcontroller (ports A, C and D) and reacts to what changes on them. A write strobe on a port applies a new external value, but only the bits configured as inputs take it; every other bit keeps its previous value. On port A, the change of each bit is then examined in the same clock. Bit 7 feeds an event counter whose counted edge is selectable, and which raises a sticky overflow flag when it wraps. The low bits feed input-capture channels: each has a two-bit edge selector, and a selected edge latches the 16-bit free-running timer count into that channel's holding register and sets its sticky flag.

Capture channels are numbered in reverse of the port bits: port bit 0 fills the highest-numbered channel. Every write that sets a flag also produces a one-cycle pulse so that the interrupt logic around the block can re-evaluate pending requests. Flags stay set until a clear input removes them, and a new event always wins over a clear arriving in the same cycle.

Top module: `pcap_top`

## Requirements
- R1: While rst_n is low and in the first cycle after it, port_a, port_c, port_d, acc_count, ovf_flag, cap_flags, cap_bus and irq_eval are all zero.
- R2: A wr_a strobe updates port_a one clock later. Bits 0 and 1 always take ext_a. Bit 7 takes ext_a only when pa7_out is 0. Bits 2 to 6 keep their old value. Without a strobe, port_a does not change.
- R3: A wr_c (wr_d) strobe updates port_c (port_d) one clock later. Bits whose dir_c (dir_d) bit is 1 take the external value, and the other bits keep their old value. C and D may be written in the same cycle.
- R4: When acc_en is 1 and acc_gated is 0, each change of port_a bit 7 caused by a write increments acc_count by one if the new level matches acc_rise (acc_rise=1 counts 0-to-1, acc_rise=0 counts 1-to-0).
- R5: acc_count does not change when acc_en is 0, when acc_gated is 1, or when bit 7 does not change (including when pa7_out=1 blocks it).
- R6: An increment that wraps acc_count from 8'hFF to 8'h00 sets ovf_flag and pulses irq_eval in the same cycle the count becomes zero.
- R7: Port A bit i (i = 0..2) uses edge_cfg[2i+1:2i]: code 0 captures never, 1 on a 0-to-1 change, 2 on a 1-to-0 change, 3 on either change. A capture sets cap_flags[i] one clock after the strobe.
- R8: A capture on port bit i stores tmr_count, as sampled at the clock edge of the strobe, into channel 3-i. Channel k occupies cap_bus[16k-1:16k-16], so bit 0 fills cap_bus[47:32], bit 1 fills cap_bus[31:16] and bit 2 fills cap_bus[15:0]. Other channels keep their values.
- R9: Several channels that see a selected edge on the same write all capture the same count and all set their flags together.
- R10: cap_flags and ovf_flag stay set until the matching cap_clr or ovf_clr bit is high at a clock edge; when a set and a clear happen in the same cycle, the flag ends set.
- R11: irq_eval is high for exactly the one cycle after a write strobe that set any capture flag or the overflow flag, and low otherwise.
- R12: Port A bit 2 is never writable from outside with the default input mask, so its capture channel never fires from an external write and cap_bus[15:0] stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_a | input | 1 | Apply ext_a to port A |
| ext_a | input | 8 | External value for port A |
| wr_c | input | 1 | Apply ext_c to port C |
| ext_c | input | 8 | External value for port C |
| wr_d | input | 1 | Apply ext_d to port D |
| ext_d | input | 8 | External value for port D |
| pa7_out | input | 1 | Port A bit 7 is an output (blocks external writes to it) |
| acc_en | input | 1 | Event counter enable |
| acc_gated | input | 1 | Gated-time mode selected (event counting suspended) |
| acc_rise | input | 1 | 1: count rising changes of bit 7, 0: falling |
| edge_cfg | input | 6 | Two-bit capture edge code per port A bit 0..2 |
| dir_c | input | 8 | Port C direction, 1 = bit accepts external value |
| dir_d | input | 8 | Port D direction, 1 = bit accepts external value |
| tmr_count | input | 16 | Free-running timer count |
| cap_clr | input | 3 | Clear capture flags, one bit per port bit |
| ovf_clr | input | 1 | Clear the overflow flag |
| port_a | output | 8 | Port A input register |
| port_c | output | 8 | Port C input register |
| port_d | output | 8 | Port D input register |
| acc_count | output | 8 | Event counter |
| ovf_flag | output | 1 | Sticky event counter overflow flag |
| cap_flags | output | 3 | Sticky capture flags, bit i for port A bit i |
| cap_bus | output | 48 | Capture holding registers, channel k at [16k-1:16k-16] |
| irq_eval | output | 1 | One-cycle request to re-evaluate interrupts |

## Verification
The hardest state to reach is the counter wrap: ovf_flag only rises after 256 counted transitions of port A bit 7, each of which needs its own write. The stimulus starts from a known count left by the counting tests and alternates writes of 8'h80 and 8'h00 with rising edges selected, stopping one short of the wrap to check 8'hFF before the final edge. The set-versus-clear race of the sticky flags is reached by raising cap_clr in the very cycle of a write that produces a capture.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2,
      EDGE_ANY  = 2'd3
   } edge_sel_t;

   // True when a changed bit with new level lvl matches the selector.
   function automatic logic edge_hit(input logic [1:0] code, input logic lvl);
      logic r;
      case (edge_sel_t'(code))
         EDGE_OFF:  r = 1'b0;
         EDGE_RISE: r = lvl;
         EDGE_FALL: r = ~lvl;
         default:   r = 1'b1;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pcap_masked_reg.sv
module pcap_masked_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] din,
   input  logic [W-1:0] wmask,
   output logic [W-1:0] q,
   output logic [W-1:0] nxt,
   output logic [W-1:0] chg
);

   assign nxt = (din & wmask) | (q & ~wmask);
   assign chg = wr ? (nxt ^ q) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (wr)
         q <= nxt;
   end

endmodule

// File: rtl/pcap_capture_ch.sv
module pcap_capture_ch #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          chg,
   input  logic          lvl,
   input  logic [1:0]    sel,
   input  logic          clr,
   input  logic [TW-1:0] tmr,
   output logic          flag,
   output logic [TW-1:0] hold,
   output logic          hit
);
   import pcap_pkg::*;

   assign hit = chg & edge_hit(sel, lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         hold <= '0;
      end else begin
         flag <= hit | (flag & ~clr);
         if (hit)
            hold <= tmr;
      end
   end

endmodule

// File: rtl/pcap_accum.sv
module pcap_accum #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          chg,
   input  logic          lvl,
   input  logic          en,
   input  logic          gated,
   input  logic          rise,
   input  logic          clr,
   output logic [AW-1:0] count,
   output logic          ovf_flag,
   output logic          ovf_hit
);

   localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

   logic inc;

   assign inc     = chg & en & ~gated & (rise ? lvl : ~lvl);
   assign ovf_hit = inc & (&count);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= '0;
         ovf_flag <= 1'b0;
      end else begin
         if (inc)
            count <= count + ONE;
         ovf_flag <= ovf_hit | (ovf_flag & ~clr);
      end
   end

endmodule

// File: rtl/pcap_top.sv
module pcap_top #(
   parameter int          W          = 8,
   parameter int          TW         = 16,
   parameter int          NCAP       = 3,
   parameter int          AW         = 8,
   parameter int          PA_ACC_BIT = 7,
   parameter logic [W-1:0] PA_IN_MASK = 8'h03
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_a,
   input  logic [W-1:0]       ext_a,
   input  logic               wr_c,
   input  logic [W-1:0]       ext_c,
   input  logic               wr_d,
   input  logic [W-1:0]       ext_d,
   input  logic               pa7_out,
   input  logic               acc_en,
   input  logic               acc_gated,
   input  logic               acc_rise,
   input  logic [2*NCAP-1:0]  edge_cfg,
   input  logic [W-1:0]       dir_c,
   input  logic [W-1:0]       dir_d,
   input  logic [TW-1:0]      tmr_count,
   input  logic [NCAP-1:0]    cap_clr,
   input  logic               ovf_clr,
   output logic [W-1:0]       port_a,
   output logic [W-1:0]       port_c,
   output logic [W-1:0]       port_d,
   output logic [AW-1:0]      acc_count,
   output logic               ovf_flag,
   output logic [NCAP-1:0]    cap_flags,
   output logic [NCAP*TW-1:0] cap_bus,
   output logic               irq_eval
);

   localparam logic [W-1:0] ACC_BIT_MASK = {{(W-1){1'b0}}, 1'b1} << PA_ACC_BIT;

   // elaboration-time parameter checks
   if (NCAP < 1 || NCAP > W) begin : g_bad_ncap
      $error("pcap_top: NCAP must be between 1 and W");
   end
   if (PA_ACC_BIT < NCAP || PA_ACC_BIT >= W) begin : g_bad_accbit
      $error("pcap_top: PA_ACC_BIT must lie above the capture bits and inside W");
   end
   if (TW < 1 || AW < 2) begin : g_bad_width
      $error("pcap_top: TW and AW too small");
   end

   logic [W-1:0]    a_mask, a_nxt, a_chg;
   logic [W-1:0]    c_nxt, c_chg, d_nxt, d_chg;
   logic [NCAP-1:0] cap_hit;
   logic            ovf_hit;

   assign a_mask = PA_IN_MASK | (pa7_out ? '0 : ACC_BIT_MASK);

   pcap_masked_reg #(.W(W)) u_pa (
      .clk(clk), .rst_n(rst_n), .wr(wr_a), .din(ext_a), .wmask(a_mask),
      .q(port_a), .nxt(a_nxt), .chg(a_chg));

   pcap_masked_reg #(.W(W)) u_pc (
      .clk(clk), .rst_n(rst_n), .wr(wr_c), .din(ext_c), .wmask(dir_c),
      .q(port_c), .nxt(c_nxt), .chg(c_chg));

   pcap_masked_reg #(.W(W)) u_pd (
      .clk(clk), .rst_n(rst_n), .wr(wr_d), .din(ext_d), .wmask(dir_d),
      .q(port_d), .nxt(d_nxt), .chg(d_chg));

   pcap_accum #(.AW(AW)) u_acc (
      .clk(clk), .rst_n(rst_n),
      .chg(a_chg[PA_ACC_BIT]), .lvl(a_nxt[PA_ACC_BIT]),
      .en(acc_en), .gated(acc_gated), .rise(acc_rise), .clr(ovf_clr),
      .count(acc_count), .ovf_flag(ovf_flag), .ovf_hit(ovf_hit));

   // Port bit i feeds channel NCAP-i, held in slice NCAP-1-i of cap_bus.
   for (genvar i = 0; i < NCAP; i++) begin : g_cap
      localparam int SL = NCAP - 1 - i;
      pcap_capture_ch #(.TW(TW)) u_ch (
         .clk(clk), .rst_n(rst_n),
         .chg(a_chg[i]), .lvl(a_nxt[i]),
         .sel(edge_cfg[2*i+1 -: 2]), .clr(cap_clr[i]), .tmr(tmr_count),
         .flag(cap_flags[i]), .hold(cap_bus[SL*TW +: TW]), .hit(cap_hit[i]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_eval <= 1'b0;
      else
         irq_eval <= (|cap_hit) | ovf_hit;
   end

endmodule

// File: rtl/pcap_chk.sv
module pcap_chk #(
   parameter int W          = 8,
   parameter int TW         = 16,
   parameter int NCAP       = 3,
   parameter int AW         = 8,
   parameter int PA_ACC_BIT = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_a,
   input logic [W-1:0]       ext_a,
   input logic               wr_c,
   input logic [W-1:0]       dir_c,
   input logic               pa7_out,
   input logic [TW-1:0]      tmr_count,
   input logic [W-1:0]       port_a,
   input logic [W-1:0]       port_c,
   input logic [AW-1:0]      acc_count,
   input logic               ovf_flag,
   input logic [NCAP-1:0]    cap_flags,
   input logic [NCAP*TW-1:0] cap_bus,
   input logic               irq_eval
);

   assert_a_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_a |=> $stable(port_a));

   assert_a7_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_a && !pa7_out) |=> port_a[PA_ACC_BIT] == $past(ext_a[PA_ACC_BIT]));

   assert_c_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_c |=> ((port_c ^ $past(port_c)) & ~$past(dir_c)) == '0);

   assert_acc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (acc_count == $past(acc_count)) ||
               (acc_count == AW'($past(acc_count) + 1'b1)));

   assert_ovf_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> (acc_count == '0 && irq_eval));

   assert_flag_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_flags[0]) |-> irq_eval);

   assert_cap_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_flags[0]) |-> cap_bus[NCAP*TW-1 -: TW] == $past(tmr_count));

   assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_eval |-> $past(wr_a));

endmodule

bind pcap_top pcap_chk #(
   .W(W), .TW(TW), .NCAP(NCAP), .AW(AW), .PA_ACC_BIT(PA_ACC_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_a(wr_a), .ext_a(ext_a), .wr_c(wr_c),
   .dir_c(dir_c), .pa7_out(pa7_out), .tmr_count(tmr_count),
   .port_a(port_a), .port_c(port_c), .acc_count(acc_count),
   .ovf_flag(ovf_flag), .cap_flags(cap_flags), .cap_bus(cap_bus),
   .irq_eval(irq_eval)
);

// File: tb/sim_pcap_top.sv
`timescale 1ns/1ps
module sim_pcap_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_a = 0, wr_c = 0, wr_d = 0;
   logic [7:0]  ext_a = 0, ext_c = 0, ext_d = 0;
   logic        pa7_out = 0, acc_en = 0, acc_gated = 0, acc_rise = 1;
   logic [5:0]  edge_cfg = 0;
   logic [7:0]  dir_c = 0, dir_d = 0;
   logic [15:0] tmr_count = 16'h1234;
   logic [2:0]  cap_clr = 0;
   logic        ovf_clr = 0;
   logic [7:0]  port_a, port_c, port_d, acc_count;
   logic        ovf_flag, irq_eval;
   logic [2:0]  cap_flags;
   logic [47:0] cap_bus;

   int checks = 0;
   int fails = 0;
   logic [7:0] pa_exp = 0;

   always #5 clk = ~clk;
   always_ff @(posedge clk) tmr_count <= tmr_count + 16'd13;

   pcap_top u0 (
      .clk(clk), .rst_n(rst_n), .wr_a(wr_a), .ext_a(ext_a), .wr_c(wr_c),
      .ext_c(ext_c), .wr_d(wr_d), .ext_d(ext_d), .pa7_out(pa7_out),
      .acc_en(acc_en), .acc_gated(acc_gated), .acc_rise(acc_rise),
      .edge_cfg(edge_cfg), .dir_c(dir_c), .dir_d(dir_d),
      .tmr_count(tmr_count), .cap_clr(cap_clr), .ovf_clr(ovf_clr),
      .port_a(port_a), .port_c(port_c), .port_d(port_d),
      .acc_count(acc_count), .ovf_flag(ovf_flag), .cap_flags(cap_flags),
      .cap_bus(cap_bus), .irq_eval(irq_eval));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Write port A; returns the timer value the block samples.
   task automatic wa(input logic [7:0] v, output logic [15:0] t);
      logic [7:0] m;
      m = pa7_out ? 8'h03 : 8'h83;
      ext_a = v; wr_a = 1'b1; t = tmr_count;
      @(negedge clk);
      wr_a = 1'b0;
      pa_exp = (v & m) | (pa_exp & ~m);
   endtask

   task automatic t_reset();
      check("R1 port_a", port_a, 0);
      check("R1 port_c/d", {port_c, port_d}, 0);
      check("R1 acc/ovf", {acc_count, ovf_flag}, 0);
      check("R1 flags/irq", {cap_flags, irq_eval}, 0);
      check("R1 cap_bus", cap_bus, 0);
   endtask

   task automatic t_port_a_mask();
      logic [15:0] t;
      pa7_out = 0;
      wa(8'hFF, t);
      check("R2 mask 0x83", port_a, 8'h83);
      pa7_out = 1;
      wa(8'h00, t);
      check("R2 bit7 output kept", port_a, 8'h80);
      check("R2 model", port_a, pa_exp);
      repeat (2) @(negedge clk);
      check("R2 no strobe stable", port_a, 8'h80);
      check("R5 counter idle", acc_count, 0);
      check("R7 code0 no flags", cap_flags, 0);
   endtask

   task automatic t_port_cd();
      dir_c = 8'hF0; ext_c = 8'hAB; wr_c = 1;
      @(negedge clk); wr_c = 0;
      check("R3 port_c dir F0", port_c, 8'hA0);
      dir_c = 8'h0F; ext_c = 8'h55; wr_c = 1;
      dir_d = 8'h3C; ext_d = 8'hFF; wr_d = 1;
      @(negedge clk); wr_c = 0; wr_d = 0;
      check("R3 port_c dir 0F", port_c, 8'hA5);
      check("R3 port_d dir 3C", port_d, 8'h3C);
      check("R11 no flag no irq", irq_eval, 0);
   endtask

   task automatic t_accum();
      logic [15:0] t;
      pa7_out = 0; acc_en = 1; acc_gated = 0; acc_rise = 1;
      wa(8'h00, t);
      check("R4 fall ignored when rise", acc_count, 0);
      wa(8'h80, t);
      check("R4 rise counted", acc_count, 1);
      wa(8'h80, t);
      check("R5 no change no count", acc_count, 1);
      acc_rise = 0;
      wa(8'h00, t);
      check("R4 fall counted", acc_count, 2);
      acc_gated = 1;
      wa(8'h80, t);
      check("R5 gated no count", acc_count, 2);
      acc_gated = 0; acc_en = 0;
      wa(8'h00, t);
      check("R5 disabled no count", acc_count, 2);
      acc_en = 1; acc_rise = 1; pa7_out = 1;
      wa(8'h80, t);
      check("R5 bit7 output no count", {acc_count, port_a}, {8'd2, 8'h00});
      pa7_out = 0;
   endtask

   task automatic t_overflow();
      logic [15:0] t;
      acc_en = 1; acc_rise = 1;
      for (int k = 0; k < 253; k++) begin
         wa(8'h80, t);
         wa(8'h00, t);
      end
      check("R6 at FF", {acc_count, ovf_flag}, {8'hFF, 1'b0});
      wa(8'h80, t);
      check("R6 wrap count", acc_count, 0);
      check("R6 ovf set", ovf_flag, 1);
      check("R6 irq pulse", irq_eval, 1);
      @(negedge clk);
      check("R11 pulse one cycle", irq_eval, 0);
      check("R10 ovf sticky", ovf_flag, 1);
      ovf_clr = 1; @(negedge clk); ovf_clr = 0;
      check("R10 ovf cleared", ovf_flag, 0);
      acc_en = 0;
      wa(8'h00, t);
   endtask

   task automatic t_capture_codes();
      logic [15:0] t, t0;
      edge_cfg = 6'b00_10_01;
      wa(8'h01, t0);
      check("R7 rise bit0 flag", cap_flags, 3'b001);
      check("R8 bit0 to ch3", cap_bus[47:32], t0);
      check("R11 capture irq", irq_eval, 1);
      wa(8'h00, t);
      check("R7 code1 ignores fall", {cap_flags, cap_bus[47:32]}, {3'b001, t0});
      wa(8'h02, t);
      check("R7 code2 ignores rise", cap_flags, 3'b001);
      wa(8'h00, t);
      check("R7 code2 fall flag", cap_flags, 3'b011);
      check("R8 bit1 to ch2", cap_bus[31:16], t);
      check("R8 ch3 kept", cap_bus[47:32], t0);
   endtask

   task automatic t_multi();
      logic [15:0] t;
      cap_clr = 3'b111; @(negedge clk); cap_clr = 0;
      check("R10 flags cleared", cap_flags, 0);
      edge_cfg = 6'b00_11_11;
      wa(8'h03, t);
      check("R9 both flags", cap_flags, 3'b011);
      check("R9 same count", {cap_bus[47:32], cap_bus[31:16]}, {t, t});
      wa(8'h00, t);
      check("R7 code3 fall", {cap_bus[47:32], cap_bus[31:16]}, {t, t});
      cap_clr = 3'b111; @(negedge clk); cap_clr = 0;
      edge_cfg = 6'b00_00_00;
      wa(8'h03, t);
      check("R7 code0 disabled", {cap_flags, irq_eval}, 4'b0000);
      wa(8'h00, t);
   endtask

   task automatic t_bit2();
      logic [15:0] t;
      edge_cfg = 6'b11_00_00;
      wa(8'h04, t);
      check("R12 bit2 not writable", port_a, 8'h00);
      check("R12 no bit2 capture", {cap_flags, cap_bus[15:0]}, {3'b000, 16'h0});
   endtask

   task automatic t_sticky();
      logic [15:0] t;
      edge_cfg = 6'b00_00_11;
      wa(8'h01, t);
      check("R7 flag set", cap_flags[0], 1);
      ext_c = 8'h00; wr_c = 1; @(negedge clk); wr_c = 0;
      check("R10 flag holds", cap_flags[0], 1);
      check("R11 no new flag no irq", irq_eval, 0);
      cap_clr = 3'b001;
      wa(8'h00, t);
      cap_clr = 0;
      check("R10 set beats clear", cap_flags[0], 1);
      check("R8 recapture", cap_bus[47:32], t);
      cap_clr = 3'b001; @(negedge clk); cap_clr = 0;
      check("R10 clear alone", cap_flags[0], 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_port_a_mask();
      t_port_cd();
      t_accum();
      t_overflow();
      t_capture_codes();
      t_multi();
      t_bit2();
      t_sticky();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule